// File: doc/BRIEF.md
# Cache Block Fill Walker

This block walks a contiguous run of cache blocks and issues one fill request per block toward a cache array. The start address, the run length (counted in whole blocks), the walk direction and the block-size mode are held on input pins, as a register bank would present them. A one-cycle start pulse launches the run. The block then presents requests on a valid/ready port. Each request address is one block away from the previous one, moving up or down. The tag lookup and the memory fetch sit behind that port, and the port can report a translation fault against an accepted request.

When a run ends, the busy flag drops by itself and a done flag rises. Two interrupt sources sit beside each other, one for completion and one for faults. Each source has a pending bit, a level enable and a clear pulse. A zero length or an unsupported block-size mode counts as a configuration fault: it finishes the run at once, with no request issued. A fault returned on a request stops the walk at that request.

Top module: `blk_fill_walker`

## Requirements
- R1: After reset, `run_busy`, `req_valid`, `run_done`, both pending bits and both interrupt outputs are 0.
- R2: A `go_set` pulse while idle, with a legal setup, raises `run_busy` and `req_valid` at the next clock edge and clears `run_done` at that edge.
- R3: The first request address is `start_addr` with its low bits cleared to the block size: `blk_mode` 0 selects 16 bytes, 1 selects 32 bytes and 2 selects 64 bytes.
- R4: Each later request address differs from the one before by exactly one block size. It is higher when `walk_desc` is 0 and lower when `walk_desc` is 1, and it wraps modulo 2^AW.
- R5: A run with no fault issues exactly `blk_count` accepted requests. While `req_ready` is low, `req_valid` and `req_addr` hold steady.
- R6: At the edge where the last request is accepted, `run_busy` and `req_valid` fall, and `run_done` and `done_pend` rise.
- R7: A `go_set` pulse while `run_busy` is 1 is ignored: the current run keeps its addresses and its count.
- R8: A start with `blk_count` equal to 0, or with `blk_mode` equal to 3, issues no request. At that same edge it sets `run_done`, `done_pend` and `fault_pend`.
- R9: When `req_fault` is 1 on an accepted request, the run ends at that edge. `run_done`, `done_pend` and `fault_pend` are set, and no further request is issued.
- R10: Each interrupt output equals its pending bit AND its enable input. A clear pulse drops the pending bit, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | AW | First byte address of the run |
| blk_count | input | LW | Run length in blocks |
| walk_desc | input | 1 | 1 walks downward, 0 walks upward |
| blk_mode | input | 2 | Block size: 0 = 16 B, 1 = 32 B, 2 = 64 B, 3 = illegal |
| go_set | input | 1 | Start pulse |
| done_ie | input | 1 | Completion interrupt enable |
| done_clr | input | 1 | Completion pending clear pulse |
| fault_ie | input | 1 | Fault interrupt enable |
| fault_clr | input | 1 | Fault pending clear pulse |
| req_ready | input | 1 | Cache side accepts the request |
| req_fault | input | 1 | Translation fault on the accepted request |
| req_valid | output | 1 | Fill request valid |
| req_addr | output | AW | Block-aligned fill address |
| run_busy | output | 1 | Run in progress (self-clearing start bit) |
| run_done | output | 1 | Run finished |
| done_pend | output | 1 | Completion interrupt pending |
| done_irq | output | 1 | Completion interrupt |
| fault_pend | output | 1 | Fault interrupt pending |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The assertions assume three things about the cache side. `req_fault` is only meaningful in a cycle where a request is accepted. The cache side may hold `req_ready` low for any number of cycles, but it eventually raises it. The start pulse and the clear pulses are synchronous, one-cycle strobes. The stimulus follows all three. A monitor drives `req_fault` only on the cycle of a handshake and keeps it low otherwise. The ready pattern stalls one cycle in three, so every run still finishes. Every pulse is raised just after a clock edge and lowered just after the next one.

// File: rtl/blk_walk_pkg.sv
package blk_walk_pkg;

    typedef enum logic [1:0] {
        BLK_16  = 2'd0,
        BLK_32  = 2'd1,
        BLK_64  = 2'd2,
        BLK_BAD = 2'd3
    } blk_mode_e;

    // Run end event: finish and fault qualifiers for the same edge
    typedef struct packed {
        logic finish;
        logic fault;
    } run_evt_t;

    localparam int SRC_DONE  = 0;
    localparam int SRC_FAULT = 1;
    localparam int NUM_SRC   = 2;

    function automatic logic [6:0] stride_bytes(input blk_mode_e m);
        case (m)
            BLK_16:  return 7'd16;
            BLK_32:  return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/blk_cfg_check.sv
module blk_cfg_check
    import blk_walk_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [LW-1:0] blk_count,
    input  blk_mode_e     blk_mode,
    output logic          illegal
);
    always_comb begin
        illegal = (blk_count == '0) || (blk_mode == BLK_BAD);
    end
endmodule

// File: rtl/blk_walk_core.sv
module blk_walk_core
    import blk_walk_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          illegal,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] blk_count,
    input  logic          walk_desc,
    input  blk_mode_e     blk_mode,
    input  logic          req_ready,
    input  logic          req_fault,
    output logic          busy,
    output logic [AW-1:0] addr,
    output logic          launch,
    output run_evt_t      evt
);
    logic [AW-1:0] stride_q;
    logic [AW-1:0] stride_in;
    logic [LW-1:0] remain_q;
    logic          desc_q;
    logic          accept;
    logic          last;
    logic          reject;

    always_comb begin
        stride_in  = AW'(stride_bytes(blk_mode));
        launch     = go && !busy;
        reject     = launch && illegal;
        accept     = busy && req_ready;
        last       = accept && ((remain_q == LW'(1)) || req_fault);
        evt.finish = last || reject;
        evt.fault  = (accept && req_fault) || reject;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            addr     <= '0;
            stride_q <= '0;
            remain_q <= '0;
            desc_q   <= 1'b0;
        end else if (launch && !illegal) begin
            busy     <= 1'b1;
            addr     <= start_addr & ~(stride_in - AW'(1));
            stride_q <= stride_in;
            remain_q <= blk_count;
            desc_q   <= walk_desc;
        end else if (accept) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                addr     <= desc_q ? (addr - stride_q) : (addr + stride_q);
                remain_q <= remain_q - LW'(1);
            end
        end
    end
endmodule

// File: rtl/blk_irq_cell.sv
module blk_irq_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic pend,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    always_comb irq = pend && ie;
endmodule

// File: rtl/blk_fill_walker.sv
module blk_fill_walker
    import blk_walk_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] blk_count,
    input  logic          walk_desc,
    input  logic [1:0]    blk_mode,
    input  logic          go_set,
    input  logic          done_ie,
    input  logic          done_clr,
    input  logic          fault_ie,
    input  logic          fault_clr,
    input  logic          req_ready,
    input  logic          req_fault,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          run_busy,
    output logic          run_done,
    output logic          done_pend,
    output logic          done_irq,
    output logic          fault_pend,
    output logic          fault_irq
);
    blk_mode_e mode;
    logic      illegal;
    logic      launch;
    run_evt_t  evt;

    logic [NUM_SRC-1:0] src_set, src_clr, src_ie, src_pend, src_irq;

    assign mode = blk_mode_e'(blk_mode);

    blk_cfg_check #(.LW(LW)) u_cfg (
        .blk_count (blk_count),
        .blk_mode  (mode),
        .illegal   (illegal)
    );

    blk_walk_core #(.AW(AW), .LW(LW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .go         (go_set),
        .illegal    (illegal),
        .start_addr (start_addr),
        .blk_count  (blk_count),
        .walk_desc  (walk_desc),
        .blk_mode   (mode),
        .req_ready  (req_ready),
        .req_fault  (req_fault),
        .busy       (run_busy),
        .addr       (req_addr),
        .launch     (launch),
        .evt        (evt)
    );

    assign req_valid = run_busy;

    // Done flag: cleared on a new start, set on any run end
    always_ff @(posedge clk) begin
        if (rst)             run_done <= 1'b0;
        else if (evt.finish) run_done <= 1'b1;
        else if (launch)     run_done <= 1'b0;
    end

    always_comb begin
        src_set[SRC_DONE]  = evt.finish;
        src_clr[SRC_DONE]  = done_clr;
        src_ie[SRC_DONE]   = done_ie;
        src_set[SRC_FAULT] = evt.fault;
        src_clr[SRC_FAULT] = fault_clr;
        src_ie[SRC_FAULT]  = fault_ie;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_irq
        blk_irq_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .set  (src_set[i]),
            .clr  (src_clr[i]),
            .ie   (src_ie[i]),
            .pend (src_pend[i]),
            .irq  (src_irq[i])
        );
    end

    assign done_pend  = src_pend[SRC_DONE];
    assign done_irq   = src_irq[SRC_DONE];
    assign fault_pend = src_pend[SRC_FAULT];
    assign fault_irq  = src_irq[SRC_FAULT];
endmodule

// File: rtl/blk_fill_walker_chk.sv
module blk_fill_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          go_set,
    input logic          done_ie,
    input logic          fault_ie,
    input logic          req_ready,
    input logic          req_fault,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          run_busy,
    input logic          run_done,
    input logic          done_pend,
    input logic          done_irq,
    input logic          fault_pend,
    input logic          fault_irq
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !run_busy && !run_done && !done_pend && !fault_pend); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R5

    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        run_busy && go_set && !req_ready |=> run_busy && $stable(req_addr)); // R7

    AST_DONE_PENDS: assert property (@(posedge clk) disable iff (rst)
        $rose(run_done) |-> done_pend); // R6

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_fault |=> !req_valid && run_done && fault_pend); // R9

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        (done_irq == (done_pend && done_ie)) && (fault_irq == (fault_pend && fault_ie))); // R10
endmodule

bind blk_fill_walker blk_fill_walker_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .go_set     (go_set),
    .done_ie    (done_ie),
    .fault_ie   (fault_ie),
    .req_ready  (req_ready),
    .req_fault  (req_fault),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .run_busy   (run_busy),
    .run_done   (run_done),
    .done_pend  (done_pend),
    .done_irq   (done_irq),
    .fault_pend (fault_pend),
    .fault_irq  (fault_irq)
);

// File: tb/blk_fill_walker_test.sv
module blk_fill_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] start_addr = '0;
    logic [15:0] blk_count = '0;
    logic        walk_desc = 1'b0;
    logic [1:0]  blk_mode = '0;
    logic        go_set = 1'b0, done_ie = 1'b0, done_clr = 1'b0;
    logic        fault_ie = 1'b0, fault_clr = 1'b0;
    logic        req_ready = 1'b1, req_fault = 1'b0;
    logic        req_valid, run_busy, run_done, done_pend, done_irq, fault_pend, fault_irq;
    logic [31:0] req_addr;

    int checks = 0, failures = 0;
    int acc_cnt = 0, fault_at = -1, rdy_cnt = 0;
    bit stall = 1'b0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    blk_fill_walker uut (
        .clk(clk), .rst(rst), .start_addr(start_addr), .blk_count(blk_count),
        .walk_desc(walk_desc), .blk_mode(blk_mode), .go_set(go_set),
        .done_ie(done_ie), .done_clr(done_clr), .fault_ie(fault_ie), .fault_clr(fault_clr),
        .req_ready(req_ready), .req_fault(req_fault), .req_valid(req_valid),
        .req_addr(req_addr), .run_busy(run_busy), .run_done(run_done),
        .done_pend(done_pend), .done_irq(done_irq), .fault_pend(fault_pend),
        .fault_irq(fault_irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Ready generator: stalls one cycle in three when enabled
    always @(posedge clk) begin
        #2;
        rdy_cnt++;
        req_ready = stall ? (rdy_cnt % 3 != 0) : 1'b1;
    end

    // Monitor: pops the scoreboard on each handshake
    always @(negedge clk) begin
        if (!rst && req_valid && req_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 extra request", req_addr, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(req_addr == e, "R3/R4 request address", req_addr, e);
            end
            req_fault = (fault_at >= 0) && (acc_cnt == fault_at);
            acc_cnt++;
        end else begin
            req_fault = 1'b0;
        end
    end

    task automatic push_exp(input logic [31:0] a, input int n, input bit d, input logic [1:0] m);
        logic [31:0] s, b;
        s = 32'd16 << m;
        b = a & ~(s - 32'd1);
        for (int i = 0; i < n; i++) exp_q.push_back(d ? b - s * i : b + s * i);
    endtask

    task automatic pulse_go(input logic [31:0] a, input int n, input bit d, input logic [1:0] m);
        @(posedge clk); #2;
        start_addr = a; blk_count = 16'(n); walk_desc = d; blk_mode = m; go_set = 1'b1;
        @(posedge clk); #2;
        go_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_pends();
        @(posedge clk); #2; done_clr = 1'b1; fault_clr = 1'b1;
        @(posedge clk); #2; done_clr = 1'b0; fault_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done(input bit expect_fault);
        while (!run_done) @(negedge clk);
        chk(exp_q.size() == 0, "R5 request count", exp_q.size(), 0);
        chk(!run_busy && !req_valid, "R6 busy clears", run_busy, 0);
        chk(done_pend, "R6 done pending", done_pend, 1);
        chk(fault_pend == expect_fault, "R9 fault status", fault_pend, expect_fault);
    endtask

    task automatic run_walk(input logic [31:0] a, input int n, input bit d, input logic [1:0] m, input int fidx);
        acc_cnt = 0; fault_at = fidx;
        push_exp(a, (fidx >= 0) ? fidx + 1 : n, d, m);
        pulse_go(a, n, d, m);
        chk(run_busy && req_valid, "R2 run starts", run_busy, 1);
        chk(!run_done, "R2 done cleared on start", run_done, 0);
        wait_done(fidx >= 0);
        fault_at = -1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(!run_busy && !req_valid && !run_done, "R1 reset outputs", run_busy, 0);
        chk(!done_pend && !fault_pend && !done_irq && !fault_irq, "R1 reset irq", done_pend, 0);

        // R3 R4: ascending 16-byte blocks with stalls
        stall = 1'b1;
        run_walk(32'h0000_1003, 4, 1'b0, 2'd0, -1);
        // R10: enable gates interrupt, clear drops pending
        chk(!done_irq, "R10 irq masked", done_irq, 0);
        @(posedge clk); #2 done_ie = 1'b1;
        @(negedge clk);
        chk(done_irq, "R10 irq enabled", done_irq, 1);
        clear_pends();
        chk(!done_pend && !done_irq, "R10 clear drops pending", done_pend, 0);

        // R4: descending 32-byte blocks
        run_walk(32'h0000_2047, 3, 1'b1, 2'd1, -1);
        clear_pends();
        // R4: 64-byte blocks wrapping past the top of the space
        stall = 1'b0;
        run_walk(32'hFFFF_FFC5, 2, 1'b0, 2'd2, -1);
        clear_pends();

        // R7: a start pulse during a run is ignored
        stall = 1'b1;
        acc_cnt = 0;
        push_exp(32'h0000_4000, 5, 1'b0, 2'd0);
        pulse_go(32'h0000_4000, 5, 1'b0, 2'd0);
        pulse_go(32'h0000_9000, 2, 1'b1, 2'd2);
        chk(run_busy, "R7 run continues", run_busy, 1);
        wait_done(1'b0);
        clear_pends();

        // R9: fault on the second accepted request
        run_walk(32'h0000_5000, 4, 1'b0, 2'd1, 1);
        @(posedge clk); #2 fault_ie = 1'b1;
        @(negedge clk);
        chk(fault_irq, "R10 fault irq", fault_irq, 1);
        chk(!req_valid, "R9 no request after fault", req_valid, 0);
        clear_pends();

        // R8: zero length and illegal mode
        pulse_go(32'h0000_6000, 0, 1'b0, 2'd0);
        chk(!req_valid && !run_busy, "R8 zero length no request", req_valid, 0);
        chk(run_done && fault_pend && done_pend, "R8 zero length fault", {run_done, fault_pend, done_pend}, 3'b111);
        clear_pends();
        pulse_go(32'h0000_6000, 3, 1'b0, 2'd3);
        chk(!req_valid && !run_busy, "R8 bad mode no request", req_valid, 0);
        chk(run_done && fault_pend && done_pend, "R8 bad mode fault", {run_done, fault_pend, done_pend}, 3'b111);
        clear_pends();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule